// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

This block is one 32-bit timer channel. While enabled, it counts down by one on each tick of a selected tick source. When it reaches zero it reloads from a programmable reload register on the next selected tick. Each expiry inverts an interrupt level, so software sees an edge, not a pulse.

Two tick-enable inputs feed the channel: a slow external tick (nominally 1 MHz) and a fast bus-rate tick (nominally 24 MHz). A source-select control bit picks one of them, and a clear bit selects the fast source. The control bits are static inputs driven by a surrounding register block. The channel holds its own count, reload and two match registers, and writes to these come in as strobes with a shared data word.

Match comparison is reduced to one case: a match register may only hold zero, and a zero match arms the interrupt even when the overflow interrupt is off. The pulse-mode bit is only stored, and only on channels whose index is 4 or above.

Top module: `reload_down_timer`

## Requirements
- R1: After reset, count, reload, both match registers, the interrupt level and the stored pulse bit are all 0.
- R2: The tick source is set by ctl_slow_i: 1 selects slow_tick_i and 0 selects fast_tick_i. While enabled, each selected tick lowers a nonzero count by one, and ticks on the unselected input have no effect.
- R3: While enabled, a selected tick at count 0 loads the reload value and marks an expiry. With reload 0 the count stays at 0 and expires on every selected tick.
- R4: On each expiry, irq_o inverts if ctl_ovf_irq_i is 1 or either match register holds 0. At all other times irq_o holds its value.
- R5: A count write loads wr_data_i into the counter only when ctl_en_i is 1, and it takes priority over a tick in the same cycle. A count write while disabled is dropped.
- R6: A reload write stores wr_data_i and shows it on reload_o. It does not change the running count until the next expiry or disable.
- R7: In the cycle after ctl_en_i goes from 1 to 0, the count equals the reload value.
- R8: A match write of zero stores zero. A match write of any nonzero value leaves that register unchanged.
- R9: With CHAN_IDX of 4 or more, pulse_mode_o follows ctl_pulse_i one cycle later and pulse_err_o stays 0. Below 4, pulse_mode_o stays 0 and pulse_err_o equals ctl_pulse_i.
- R10: While disabled (and not on the disable edge), the count holds its value, whatever the ticks and count writes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | Slow external tick enable |
| fast_tick_i | input | 1 | Fast bus-rate tick enable |
| ctl_en_i | input | 1 | Channel enable |
| ctl_slow_i | input | 1 | Tick source select (1 = slow) |
| ctl_ovf_irq_i | input | 1 | Overflow interrupt enable |
| ctl_pulse_i | input | 1 | Pulse-mode bit (stored only) |
| wr_count_i | input | 1 | Count write strobe |
| wr_reload_i | input | 1 | Reload write strobe |
| wr_match0_i | input | 1 | Match 0 write strobe |
| wr_match1_i | input | 1 | Match 1 write strobe |
| wr_data_i | input | CNT_W | Write data |
| count_o | output | CNT_W | Live counter value |
| reload_o | output | CNT_W | Reload register readback |
| match0_o | output | CNT_W | Match 0 readback |
| match1_o | output | CNT_W | Match 1 readback |
| irq_o | output | 1 | Toggling interrupt level |
| pulse_mode_o | output | 1 | Stored pulse bit |
| pulse_err_o | output | 1 | Pulse requested on a channel that cannot pulse |

## Verification
The assertions check on every cycle:
- decrement by one on a selected tick;
- reload at expiry;
- load on the disable edge;
- hold while disabled;
- rejection of nonzero match writes;
- the rule that irq_o changes exactly on armed expiries.

Other behaviours only the bench scenarios can show:
- that the unselected tick source is ignored;
- that a reload write leaves the running count alone until the next expiry;
- that a zero reload expires on every tick;
- how the pulse bit differs between channel indices.

A reference model in the bench follows the count and the interrupt level through a long random run, so ordering effects are covered, such as a count write landing on a tick at zero.

// File: rtl/rdt_pkg.sv
`timescale 1ns/1ps
package rdt_pkg;
  typedef enum logic {SRC_FAST = 1'b0, SRC_SLOW = 1'b1} tick_src_e;

  localparam int unsigned PULSE_MIN_IDX = 4;
  localparam int unsigned N_MATCH       = 2;

  // interrupt on expiry when overflow irq enabled or any match register is zero
  function automatic logic irq_armed(input logic ovf_en, input logic any_zero);
    return ovf_en | any_zero;
  endfunction

  function automatic logic pulse_capable(input int unsigned idx);
    return idx >= PULSE_MIN_IDX;
  endfunction
endpackage

// File: rtl/rdt_tick_mux.sv
`timescale 1ns/1ps
module rdt_tick_mux
  import rdt_pkg::*;
(
  input  logic      slow_tick_i,
  input  logic      fast_tick_i,
  input  tick_src_e src_i,
  output logic      tick_o
);
  always_comb begin
    unique case (src_i)
      SRC_SLOW: tick_o = slow_tick_i;
      default:  tick_o = fast_tick_i;
    endcase
  end
endmodule

// File: rtl/rdt_counter.sv
`timescale 1ns/1ps
module rdt_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] count_o,
  output logic         expire_o
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] count_q;
  logic         en_q;
  logic         off_edge;
  logic         load_wr;
  logic         step;

  function automatic logic [W-1:0] next_on_tick(input logic [W-1:0] cur,
                                                input logic [W-1:0] rld);
    return (cur == ZERO) ? rld : cur - 1'b1;
  endfunction

  assign off_edge = en_q & ~en_i;
  assign load_wr  = en_i & wr_i;
  assign step     = en_i & tick_i & ~wr_i;
  assign expire_o = step & (count_q == ZERO);
  assign count_o  = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      count_q <= ZERO;
    end else begin
      en_q <= en_i;
      if (off_edge)     count_q <= reload_i;
      else if (load_wr) count_q <= wr_data_i;
      else if (step)    count_q <= next_on_tick(count_q, reload_i);
    end
  end

  assert_decrement_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !wr_i && count_o != ZERO) |=> count_o == $past(count_o) - 1'b1);

  assert_wrap_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> count_o == $past(reload_i));

  assert_write_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_i) |=> count_o == $past(wr_data_i));

  assert_disable_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !en_i) |=> count_o == $past(reload_i));

  assert_hold_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !en_i) |=> $stable(count_o));
endmodule

// File: rtl/rdt_cfg_regs.sv
`timescale 1ns/1ps
module rdt_cfg_regs #(
  parameter int unsigned W  = 32,
  parameter int unsigned NM = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_reload_i,
  input  logic [NM-1:0]        wr_match_i,
  input  logic [W-1:0]         wr_data_i,
  output logic [W-1:0]         reload_o,
  output logic [NM-1:0][W-1:0] match_o,
  output logic                 any_zero_o
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0]  reload_q;
  logic [NM-1:0] is_zero;
  logic          data_zero;

  assign data_zero = (wr_data_i == ZERO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          reload_q <= ZERO;
    else if (wr_reload_i) reload_q <= wr_data_i;
  end
  assign reload_o = reload_q;

  for (genvar g = 0; g < NM; g++) begin : g_match
    logic [W-1:0] match_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        match_q <= ZERO;
      else if (wr_match_i[g] && data_zero) match_q <= ZERO;
    end
    assign match_o[g] = match_q;
    assign is_zero[g] = (match_q == ZERO);

    assert_match_reject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_match_i[g] && wr_data_i != ZERO) |=> $stable(match_o[g]));
  end

  assign any_zero_o = |is_zero;

  assert_reload_store_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_reload_i |=> reload_o == $past(wr_data_i));
endmodule

// File: rtl/rdt_irq_toggle.sv
`timescale 1ns/1ps
module rdt_irq_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic armed_i,
  output logic irq_o
);
  logic fire;
  logic irq_q;

  assign fire = expire_i & armed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   irq_q <= 1'b0;
    else if (fire) irq_q <= ~irq_q;
  end
  assign irq_o = irq_q;

  assert_irq_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && armed_i) |=> irq_o != $past(irq_o));

  assert_irq_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(expire_i && armed_i) |=> $stable(irq_o));
endmodule

// File: rtl/reload_down_timer.sv
`timescale 1ns/1ps
module reload_down_timer
  import rdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned CHAN_IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_tick_i,
  input  logic             fast_tick_i,
  input  logic             ctl_en_i,
  input  logic             ctl_slow_i,
  input  logic             ctl_ovf_irq_i,
  input  logic             ctl_pulse_i,
  input  logic             wr_count_i,
  input  logic             wr_reload_i,
  input  logic             wr_match0_i,
  input  logic             wr_match1_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] match0_o,
  output logic [CNT_W-1:0] match1_o,
  output logic             irq_o,
  output logic             pulse_mode_o,
  output logic             pulse_err_o
);
  localparam logic CAN_PULSE = pulse_capable(CHAN_IDX);

  tick_src_e                        src;
  logic                             tick;
  logic                             expire;
  logic                             any_zero;
  logic                             armed;
  logic [N_MATCH-1:0]               wr_match;
  logic [N_MATCH-1:0][CNT_W-1:0]    match;
  logic [CNT_W-1:0]                 reload;

  assign src      = ctl_slow_i ? SRC_SLOW : SRC_FAST;
  assign wr_match = {wr_match1_i, wr_match0_i};

  rdt_tick_mux u_mux (
    .slow_tick_i (slow_tick_i),
    .fast_tick_i (fast_tick_i),
    .src_i       (src),
    .tick_o      (tick)
  );

  rdt_cfg_regs #(.W(CNT_W), .NM(N_MATCH)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_reload_i (wr_reload_i),
    .wr_match_i  (wr_match),
    .wr_data_i   (wr_data_i),
    .reload_o    (reload),
    .match_o     (match),
    .any_zero_o  (any_zero)
  );

  rdt_counter #(.W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (ctl_en_i),
    .tick_i    (tick),
    .wr_i      (wr_count_i),
    .wr_data_i (wr_data_i),
    .reload_i  (reload),
    .count_o   (count_o),
    .expire_o  (expire)
  );

  assign armed = irq_armed(ctl_ovf_irq_i, any_zero);

  rdt_irq_toggle u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .armed_i  (armed),
    .irq_o    (irq_o)
  );

  assign reload_o = reload;
  assign match0_o = match[0];
  assign match1_o = match[1];

  if (CAN_PULSE) begin : g_pulse
    logic pulse_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_q <= 1'b0;
      else         pulse_q <= ctl_pulse_i;
    end
    assign pulse_mode_o = pulse_q;
    assign pulse_err_o  = 1'b0;
  end else begin : g_no_pulse
    assign pulse_mode_o = 1'b0;
    assign pulse_err_o  = ctl_pulse_i;
  end

  assert_pulse_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_err_o |-> !pulse_mode_o);

  assert_idle_no_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_en_i |=> $stable(irq_o));
endmodule

// File: tb/sim_reload_down_timer.sv
`timescale 1ns/1ps
module sim_reload_down_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st = 0, ft = 0, en = 0, sel = 0, ovf = 0, pls = 0;
  logic        wc = 0, wr = 0, wm0 = 0, wm1 = 0;
  logic [31:0] wd = '0;
  logic [31:0] cnt0, rld0, m00, m10, cnt1, rld1, m01, m11;
  logic        irq0, pm0, pe0, irq1, pm1, pe1;

  int n_run = 0;
  int n_fail = 0;

  // reference model
  logic [31:0] e_cnt, e_rld, e_m0, e_m1;
  logic        e_irq, e_enq;

  always #4 clk = ~clk;

  reload_down_timer #(.CNT_W(32), .CHAN_IDX(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(st), .fast_tick_i(ft),
    .ctl_en_i(en), .ctl_slow_i(sel), .ctl_ovf_irq_i(ovf), .ctl_pulse_i(pls),
    .wr_count_i(wc), .wr_reload_i(wr), .wr_match0_i(wm0), .wr_match1_i(wm1),
    .wr_data_i(wd), .count_o(cnt0), .reload_o(rld0), .match0_o(m00),
    .match1_o(m10), .irq_o(irq0), .pulse_mode_o(pm0), .pulse_err_o(pe0));

  reload_down_timer #(.CNT_W(32), .CHAN_IDX(5)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(st), .fast_tick_i(ft),
    .ctl_en_i(en), .ctl_slow_i(sel), .ctl_ovf_irq_i(ovf), .ctl_pulse_i(pls),
    .wr_count_i(wc), .wr_reload_i(wr), .wr_match0_i(wm0), .wr_match1_i(wm1),
    .wr_data_i(wd), .count_o(cnt1), .reload_o(rld1), .match0_o(m01),
    .match1_o(m11), .irq_o(irq1), .pulse_mode_o(pm1), .pulse_err_o(pe1));

  function automatic logic pick_tick(input logic s, input logic f, input logic slow);
    if (slow) return s;
    return f;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_cnt <= 0; e_rld <= 0; e_m0 <= 0; e_m1 <= 0; e_irq <= 0; e_enq <= 0;
    end else begin
      e_enq <= en;
      if (wr) e_rld <= wd;
      if (wm0 && wd == 0) e_m0 <= 0;
      if (wm1 && wd == 0) e_m1 <= 0;
      if (e_enq && !en) e_cnt <= e_rld;
      else if (en && wc) e_cnt <= wd;
      else if (en && pick_tick(st, ft, sel)) begin
        if (e_cnt == 0) begin
          e_cnt <= e_rld;
          if (ovf || e_m0 == 0 || e_m1 == 0) e_irq <= ~e_irq;
        end else e_cnt <= e_cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic cmp_model();
    chk(cnt0 == e_cnt, "R2/R3/R5 count u0", cnt0, e_cnt);
    chk(cnt1 == e_cnt, "R2/R3/R5 count u1", cnt1, e_cnt);
    chk(irq0 == e_irq, "R4 irq", {31'd0, irq0}, {31'd0, e_irq});
    chk(rld0 == e_rld, "R6 reload", rld0, e_rld);
    chk(m00 == e_m0 && m10 == e_m1, "R8 match", m00 | m10, e_m0 | e_m1);
  endtask

  task automatic quiet();
    st = 0; ft = 0; wc = 0; wr = 0; wm0 = 0; wm1 = 0;
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #1;
    step(); step();
    // R1 reset state
    chk(cnt0 == 0, "R1 count", cnt0, 0);
    chk(rld0 == 0, "R1 reload", rld0, 0);
    chk(m00 == 0 && m10 == 0, "R1 match", m00 | m10, 0);
    chk(irq0 == 0, "R1 irq", {31'd0, irq0}, 0);
    chk(pm1 == 0, "R1 pulse", {31'd0, pm1}, 0);
    rst_n = 1'b1;
    step();

    // R5 count write while disabled is dropped
    wc = 1; wd = 32'h77; step(); quiet(); step();
    chk(cnt0 == 0, "R5 dropped write", cnt0, 0);

    // R6 reload write does not disturb the running count
    en = 1; wc = 1; wd = 3; step(); quiet();
    wr = 1; wd = 10; step(); quiet();
    chk(rld0 == 10, "R6 reload readback", rld0, 10);
    chk(cnt0 == 3, "R6 count untouched", cnt0, 3);

    // R2 unselected (slow) tick ignored with fast source
    sel = 0; st = 1; step(); quiet();
    chk(cnt0 == 3, "R2 unselected tick", cnt0, 3);
    sel = 1; st = 1; step(); quiet();
    chk(cnt0 == 2, "R2 slow tick", cnt0, 2);
    sel = 1; ft = 1; step(); quiet();
    chk(cnt0 == 2, "R2 fast ignored", cnt0, 2);
    sel = 0;

    // R3/R4 expiry reloads and toggles irq (match zero arms it)
    ft = 1; step(); step(); step(); quiet();
    chk(cnt0 == 10, "R3 reload on expiry", cnt0, 10);
    chk(irq0 == 1, "R4 toggle on expiry", {31'd0, irq0}, 1);

    // R8 nonzero match writes rejected
    wm0 = 1; wm1 = 1; wd = 5; step(); quiet();
    chk(m00 == 0 && m10 == 0, "R8 nonzero rejected", m00 | m10, 0);

    // R7 disable loads reload, R10 hold while disabled
    ft = 1; step(); step(); quiet();
    en = 0; step();
    chk(cnt0 == 10, "R7 disable load", cnt0, 10);
    ft = 1; st = 1; wc = 1; wd = 1; step(); step(); quiet();
    chk(cnt0 == 10, "R10 hold", cnt0, 10);

    // R3 zero reload expires every tick
    wr = 1; wd = 0; step(); quiet();
    en = 1; wc = 1; wd = 0; step(); quiet();
    for (int i = 0; i < 4; i++) begin
      logic prev;
      prev = irq0;
      ft = 1; step();
      chk(cnt0 == 0, "R3 zero reload count", cnt0, 0);
      chk(irq0 == ~prev, "R3 zero reload expiry", {31'd0, irq0}, {31'd0, ~prev});
    end
    quiet();

    // R9 pulse bit by channel index
    pls = 1; step();
    chk(pm1 == 1 && pe1 == 0, "R9 capable stores", {30'd0, pm1, pe1}, 32'h2);
    chk(pm0 == 0 && pe0 == 1, "R9 low channel error", {30'd0, pm0, pe0}, 32'h1);
    pls = 0; step();
    chk(pm1 == 0, "R9 capable clears", {31'd0, pm1}, 0);

    // random run against the model
    for (int k = 0; k < 4000; k++) begin
      en  = ($urandom % 10) != 0;
      if ($urandom % 40 == 0) sel = ~sel;
      ovf = $urandom % 2;
      st  = $urandom % 2;
      ft  = $urandom % 2;
      wc  = ($urandom % 20) == 0;
      wr  = ($urandom % 15) == 0;
      wm0 = ($urandom % 25) == 0;
      wm1 = ($urandom % 25) == 0;
      wd  = ($urandom % 4 != 0) ? ($urandom % 6) : $urandom;
      step();
      cmp_model();
    end
    quiet(); en = 0;
    step();
    cmp_model();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule